// File: doc/BRIEF.md
# Clock Band Detector and Failover Controller

This block supervises a frequency-multiplying clock generator. It counts rising edges of a primary and a backup input clock over fixed windows of a local measurement clock. It sorts each count into one of six octave-spaced frequency bands, or marks the input invalid. From the band of the chosen input and a range-select input, it derives the loop's multiply and divide settings. This keeps the synthesized output in the same range whichever input drives the loop.

The primary input is preferred. When it stops, or its rate leaves every band, the block selects the backup input and re-derives the ratio from the backup's own band. When the primary returns and is confirmed, the block selects the primary again. An active-low lock flag reads low only while the loop runs from a healthy primary. The flag goes high when the primary's rate comes close to the edge of its band, standing for the tuning limit of the oscillator. Driving the active-low enable input low clears all state.

The regenerated-clock path of the generator always follows the active input at ratio 1. It is selected by the same source output and takes no setting from this block. The analog loop, the oscillator and the output buffers lie outside the block.

Top module: `clk_band_supervisor`

## Requirements
- R1: A window is `WIN` measurement-clock cycles. A count c taken over one window falls in band b (b = 0..5) when `BAND_MIN<<b` <= c <= `BAND_MAX<<b`. A count in no band, including zero, is out of band.
- R2: An input becomes valid at the end of the second consecutive window that lands in the same band. It becomes invalid at the end of any window that is out of band, or whose band differs from the window before it.
- R3: At each decision, a valid primary sets `src_sel` to 0. If the primary is not valid and the backup is valid, `src_sel` is set to 1.
- R4: With e = (`sel_mode` ? 5 : 3) - b, where b is the band of the selected input, `mul_log2` is set to max(e,0) and `div_log2` to max(-e,0). This gives x8 in low mode and x32 in high mode at band 0.
- R5: At each decision, `lock_n` is set low only when the primary is valid, selected and not near its band edge. In every other case it is set high, including while running from the backup.
- R6: A primary count in band b is near the edge when c < `(BAND_MIN+EDGE_MG)<<b` or c > `(BAND_MAX-EDGE_MG)<<b`. It then stays selected, with `lock_n` high.
- R7: Outputs change only on the clock edge one cycle after a window ends. Windows end at clock edges k*`WIN` counted from the release of `pwr_en`, so outputs update at edge k*`WIN`+1.
- R8: While `pwr_en` is low, the block holds `src_sel`=0, `mul_log2`=0, `div_log2`=0, `out_en`=0 and `lock_n`=1, and all counts and validity are cleared.
- R9: When neither input is valid, `src_sel`, `mul_log2`, `div_log2` and `out_en` hold their values and `lock_n` is high.
- R10: `out_en` rises at the first decision that finds a valid input and stays high until power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| meas_clk | input | 1 | Local measurement clock |
| pwr_en | input | 1 | Active-low power-down; low clears all state |
| sel_mode | input | 1 | Output range: 0 low range, 1 high range (four times higher) |
| prim_clk | input | 1 | Primary input clock, sampled asynchronously |
| bkup_clk | input | 1 | Backup input clock, sampled asynchronously |
| src_sel | output | 1 | Loop source: 0 primary, 1 backup |
| mul_log2 | output | 3 | Feedback multiply, log2 |
| div_log2 | output | 3 | Output divide, log2 |
| out_en | output | 1 | Outputs enabled |
| lock_n | output | 1 | Low while locked to a healthy primary |

## Verification
A stimulus change takes effect over several windows. One partial window is spent, and two matching full windows are needed for confirmation. The result appears at the clock edge one cycle after the confirming window ends. Steady-state checks therefore wait until the fourth window boundary after the change. The bench counts clock edges from the release of `pwr_en`. It uses that count to start a returning primary just after a boundary. It then samples on the cycle before and the cycle after the expected edge 2*`WIN`+1, and one window earlier to show that a single matching window does not switch back.

// File: rtl/clk_band_supervisor.sv
module clk_band_supervisor #(
  parameter int WIN      = 2048,
  parameter int BAND_MIN = 28,
  parameter int BAND_MAX = 36,
  parameter int EDGE_MG  = 2,
  parameter int LO_EXP   = 3,
  parameter int HI_EXP   = 5
) (
  input  logic       meas_clk,
  input  logic       pwr_en,
  input  logic       sel_mode,
  input  logic       prim_clk,
  input  logic       bkup_clk,
  output logic       src_sel,
  output logic [2:0] mul_log2,
  output logic [2:0] div_log2,
  output logic       out_en,
  output logic       lock_n
);
  localparam int CW     = $clog2(WIN + 1);
  localparam int NBANDS = 6;

  logic [CW-1:0] wcnt;
  logic          dec_q;
  logic [2:0]    sy [2];
  logic [CW-1:0] ecnt [2];
  logic [1:0]    cand_ok, vld, near_q;
  logic [2:0]    cand_b [2];
  logic [2:0]    vband [2];

  wire       win_end = (wcnt == CW'(WIN - 1));
  wire [1:0] raw     = {bkup_clk, prim_clk};
  wire [1:0] edg     = {sy[1][1] & ~sy[1][2], sy[0][1] & ~sy[0][2]};

  function automatic logic [3:0] classify(input logic [CW-1:0] c);
    int unsigned cv;
    logic [3:0]  r;
    cv = 32'(c);
    r  = 4'd0;
    for (int b = 0; b < NBANDS; b++)
      if (cv >= 32'(BAND_MIN << b) && cv <= 32'(BAND_MAX << b))
        r = {1'b1, 3'(b)};
    return r;
  endfunction

  function automatic logic near_edge(input logic [CW-1:0] c, input logic [2:0] b);
    int unsigned cv;
    cv = 32'(c);
    return (cv < 32'((BAND_MIN + EDGE_MG) << b)) || (cv > 32'((BAND_MAX - EDGE_MG) << b));
  endfunction

  function automatic logic [5:0] ratio(input logic md, input logic [2:0] b);
    int e;
    e = (md ? HI_EXP : LO_EXP) - int'(b);
    if (e >= 0) return {3'(e), 3'd0};
    else        return {3'd0, 3'(-e)};
  endfunction

  always_ff @(posedge meas_clk or negedge pwr_en) begin
    if (!pwr_en) begin
      wcnt  <= '0;
      dec_q <= 1'b0;
    end else begin
      wcnt  <= win_end ? '0 : wcnt + 1'b1;
      dec_q <= win_end;
    end
  end

  always_ff @(posedge meas_clk or negedge pwr_en) begin
    if (!pwr_en) begin
      for (int i = 0; i < 2; i++) begin
        sy[i]     <= '0;
        ecnt[i]   <= '0;
        cand_b[i] <= '0;
        vband[i]  <= '0;
      end
      cand_ok <= '0;
      vld     <= '0;
      near_q  <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        logic [CW-1:0] cnow;
        logic [3:0]    cls;
        sy[i] <= {sy[i][1:0], raw[i]};
        cnow  = ecnt[i] + CW'(edg[i]);
        cls   = classify(cnow);
        if (win_end) begin
          ecnt[i] <= '0;
          if (!cls[3]) begin
            cand_ok[i] <= 1'b0;
            vld[i]     <= 1'b0;
            near_q[i]  <= 1'b0;
          end else begin
            cand_ok[i] <= 1'b1;
            cand_b[i]  <= cls[2:0];
            near_q[i]  <= near_edge(cnow, cls[2:0]);
            if (cand_ok[i] && cand_b[i] == cls[2:0]) begin
              vld[i]   <= 1'b1;
              vband[i] <= cls[2:0];
            end else begin
              vld[i]   <= 1'b0;
            end
          end
        end else begin
          ecnt[i] <= cnow;
        end
      end
    end
  end

  always_ff @(posedge meas_clk or negedge pwr_en) begin
    if (!pwr_en) begin
      src_sel  <= 1'b0;
      mul_log2 <= '0;
      div_log2 <= '0;
      out_en   <= 1'b0;
      lock_n   <= 1'b1;
    end else if (dec_q) begin
      if (vld[0]) begin
        src_sel                <= 1'b0;
        {mul_log2, div_log2}   <= ratio(sel_mode, vband[0]);
        out_en                 <= 1'b1;
        lock_n                 <= near_q[0];
      end else if (vld[1]) begin
        src_sel                <= 1'b1;
        {mul_log2, div_log2}   <= ratio(sel_mode, vband[1]);
        out_en                 <= 1'b1;
        lock_n                 <= 1'b1;
      end else begin
        lock_n                 <= 1'b1;
      end
    end
  end

  // R7
  upd_at_boundary_chk: assert property (@(posedge meas_clk) disable iff (!pwr_en)
    !dec_q |=> $stable({src_sel, mul_log2, div_log2, out_en, lock_n}));

  // R5
  lock_src_chk: assert property (@(posedge meas_clk) disable iff (!pwr_en)
    !lock_n |-> (src_sel == 1'b0 && out_en));

  // R10
  out_en_sticky_chk: assert property (@(posedge meas_clk) disable iff (!pwr_en)
    out_en |=> out_en);

  // R4
  ratio_excl_chk: assert property (@(posedge meas_clk) disable iff (!pwr_en)
    !(mul_log2 != 3'd0 && div_log2 != 3'd0));

  // R2
  valid_needs_cand_chk: assert property (@(posedge meas_clk) disable iff (!pwr_en)
    $rose(vld[0]) |-> $past(cand_ok[0] && win_end));
endmodule

// File: tb/tb_clk_band_supervisor.sv
module tb_clk_band_supervisor;
  localparam int WIN = 2048;

  logic       clk = 1'b0;
  logic       pwr_en = 1'b0;
  logic       sel_mode = 1'b0;
  logic       prim_clk = 1'b0;
  logic       bkup_clk = 1'b0;
  logic       src_sel, out_en, lock_n;
  logic [2:0] mul_log2, div_log2;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int ph_p = 0, ph_b = 0, pc_p = 0, pc_b = 0;

  clk_band_supervisor #(.WIN(WIN)) dut (
    .meas_clk(clk), .pwr_en(pwr_en), .sel_mode(sel_mode),
    .prim_clk(prim_clk), .bkup_clk(bkup_clk),
    .src_sel(src_sel), .mul_log2(mul_log2), .div_log2(div_log2),
    .out_en(out_en), .lock_n(lock_n));

  always #2 clk = ~clk;

  always @(posedge clk or negedge pwr_en)
    if (!pwr_en) cyc <= 0; else cyc <= cyc + 1;

  always @(negedge clk) begin
    if (ph_p == 0) begin prim_clk <= 1'b0; pc_p <= 0; end
    else if (pc_p >= ph_p - 1) begin prim_clk <= ~prim_clk; pc_p <= 0; end
    else pc_p <= pc_p + 1;
    if (ph_b == 0) begin bkup_clk <= 1'b0; pc_b <= 0; end
    else if (pc_b >= ph_b - 1) begin bkup_clk <= ~bkup_clk; pc_b <= 0; end
    else pc_b <= pc_b + 1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic settle();
    wait_to(((cyc / WIN) + 4) * WIN + 2);
  endtask

  task automatic expect_out(input string req, input int s, input int m, input int d, input int oe, input int lk);
    chk(req, "src_sel", int'(src_sel), s);
    chk(req, "mul_log2", int'(mul_log2), m);
    chk(req, "div_log2", int'(div_log2), d);
    chk(req, "out_en", int'(out_en), oe);
    chk(req, "lock_n", int'(lock_n), lk);
  endtask

  task automatic power_cycle();
    @(negedge clk);
    pwr_en = 1'b0;
    repeat (3) @(negedge clk);
    expect_out("R8", 0, 0, 0, 0, 1);
    pwr_en = 1'b1;
  endtask

  // R1 R3 R4 R5 R10: primary in band 3, both modes
  task automatic t_band3();
    ph_p = 4; ph_b = 0; sel_mode = 1'b0;
    settle();
    expect_out("R10", 0, 0, 0, 1, 0);
    sel_mode = 1'b1;
    settle();
    expect_out("R4", 0, 2, 0, 1, 0);
  endtask

  // R1 R4: lowest band
  task automatic t_band0();
    ph_p = 32; sel_mode = 1'b1;
    settle();
    expect_out("R4", 0, 5, 0, 1, 0);
    sel_mode = 1'b0;
    settle();
    expect_out("R4", 0, 3, 0, 1, 0);
  endtask

  // R1 R4: highest band
  task automatic t_band5();
    ph_p = 1; sel_mode = 1'b0;
    settle();
    expect_out("R4", 0, 0, 2, 1, 0);
    sel_mode = 1'b1;
    settle();
    expect_out("R4", 0, 0, 0, 1, 0);
    sel_mode = 1'b0;
  endtask

  // R3 R5: failover to backup in band 1
  task automatic t_failover();
    ph_b = 16;
    settle();
    ph_p = 0;
    settle();
    expect_out("R3", 1, 2, 0, 1, 1);
  endtask

  // R2 R7: primary returns aligned to a window boundary
  task automatic t_return();
    int k;
    k = (cyc / WIN) + 1;
    wait_to(k * WIN + 2);
    ph_p = 4;
    wait_to((k + 1) * WIN + 4);
    chk("R2", "src after one window", int'(src_sel), 1);
    wait_to((k + 2) * WIN);
    chk("R7", "src before update edge", int'(src_sel), 1);
    wait_to((k + 2) * WIN + 1);
    chk("R7", "src at update edge", int'(src_sel), 0);
    chk("R5", "lock_n after return", int'(lock_n), 0);
    chk("R4", "mul after return", int'(mul_log2), 0);
  endtask

  // R1 R6: primary just inside and just outside band 0
  task automatic t_drift();
    ph_p = 36;
    settle();
    expect_out("R6", 0, 3, 0, 1, 1);
    ph_p = 40;
    settle();
    expect_out("R1", 1, 2, 0, 1, 1);
  endtask

  // R9: no valid input holds settings
  task automatic t_holdover();
    ph_p = 0;
    settle();
    ph_b = 0;
    settle();
    expect_out("R9", 1, 2, 0, 1, 1);
  endtask

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R8", 0, 0, 0, 0, 1);
    pwr_en = 1'b1;
    t_band3();
    t_band0();
    t_band5();
    t_failover();
    t_return();
    t_drift();
    t_holdover();
    power_cycle();
    ph_p = 8;
    settle();
    expect_out("R3", 0, 1, 0, 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule